// File: doc/BRIEF.md
# Welch Sliding-Window Spectrum Sequencer

This block wraps an external FFT engine to produce a Welch power-spectrum estimate for one slow-time column of a range gate. A single start pulse begins the sequence. The block then reads four windows of 1024 samples from a 2560-sample column buffer. The window starts step by 512 samples, so consecutive windows overlap by half. Each window is streamed into the FFT.

The FFT returns 1024 magnitudes per window, in bin order. They may arrive with idle cycles between them. The block adds them bin by bin into a local accumulator that carries two guard bits. The first window overwrites the accumulator, so no clearing pass is needed between columns. When the fourth window is added, the sum is divided by four with a right shift and written back.

Once all four windows are in, the averaged spectrum streams out with its bin index. A one-cycle done pulse follows the last bin. The block then waits for the next start pulse.

Top module: `welch_seq`

## Requirements
- R1: After reset, col_rd_o, fft_in_valid_o, fft_in_last_o, avg_valid_o and done_o are all low, and no column read occurs until start_i is seen.
- R2: A start pulse in the idle state produces exactly four read bursts, one address per cycle, in this order: bases 0, 512, 1024 and 1536. Each burst covers base..base+1023 in ascending order and every address is below 2560.
- R3: Column data is taken from col_data_i one cycle after its read request. In that cycle it is presented on fft_in_data_o with fft_in_valid_o high. fft_in_last_o is high on the 1024th sample of each window and on no other sample.
- R4: The read burst of the next window begins only after all 1024 magnitudes of the current window have been returned. Returned magnitudes are accepted in bin order, with any number of idle cycles between them.
- R5: After the fourth window, the block outputs 1024 beats on consecutive cycles with avg_bin_o = 0..1023 ascending. The value for bin k is floor((m0[k]+m1[k]+m2[k]+m3[k])/4), where mw[k] is the k-th magnitude returned for window w.
- R6: done_o is high for exactly one cycle: the cycle after the bin-1023 beat.
- R7: start_i has no effect while a sequence is in progress.
- R8: The first window's magnitudes replace the accumulator contents, so a column's result does not depend on the previous column.
- R9: Four full-scale magnitudes (65535) average to 65535, with no wrap in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one column |
| col_rd_o | output | 1 | Column buffer read request |
| col_addr_o | output | 12 | Column buffer read address |
| col_data_i | input | 16 | Column buffer read data, one cycle after the request |
| fft_in_valid_o | output | 1 | Sample to FFT valid |
| fft_in_data_o | output | 16 | Sample to FFT |
| fft_in_last_o | output | 1 | Last sample of a window |
| fft_out_valid_i | input | 1 | FFT magnitude valid |
| fft_out_mag_i | input | 16 | FFT magnitude, unsigned, in bin order |
| avg_valid_o | output | 1 | Averaged bin valid |
| avg_bin_o | output | 10 | Averaged bin index |
| avg_data_o | output | 16 | Averaged magnitude |
| done_o | output | 1 | One-cycle end-of-column pulse |

## Verification
Wrong internal state shows up at the ports at different times depending on where it sits.

A corrupt window base or offset counter shows on col_addr_o at the first read of the affected window. A lost returned beat stalls the next read burst, and the watchdog catches the stall.

A wrong first-window flag or a wrong shift only surfaces later. It appears as wrong avg_data_o values in the output burst of the same column, up to about 4000 cycles after the cause. The bench compares addresses, forwarded samples and every averaged bin on each cycle against a queue-based model, so each of these faults is localized to its first wrong beat.

// File: rtl/welch_pkg.sv
package welch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_ACC,
    ST_OUT
  } welch_state_e;
endpackage

// File: rtl/welch_ram.sv
module welch_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/welch_fsm.sv
module welch_fsm
  import welch_pkg::*;
#(
  parameter int SEG_LEN = 1024,
  parameter int N_SEG   = 4,
  parameter int HOP     = 512,
  localparam int COL_LEN = (N_SEG - 1) * HOP + SEG_LEN,
  localparam int CAW     = $clog2(COL_LEN),
  localparam int BW      = $clog2(SEG_LEN),
  localparam int SW      = $clog2(N_SEG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           beat_v_i,
  output logic           col_rd_o,
  output logic [CAW-1:0] col_addr_o,
  output logic           col_last_o,
  output logic           beat_ok_o,
  output logic [BW-1:0]  beat_bin_o,
  output logic           first_seg_o,
  output logic           last_seg_o,
  output logic           out_rd_o,
  output logic [BW-1:0]  out_addr_o
);
  localparam logic [BW-1:0] BIN_LAST = BW'(SEG_LEN - 1);
  localparam logic [SW-1:0] SEG_LAST = SW'(N_SEG - 1);

  welch_state_e   state_q;
  logic [SW-1:0]  seg_q;
  logic [CAW-1:0] base_q;
  logic [BW-1:0]  ld_cnt_q;
  logic [BW-1:0]  rx_cnt_q;
  logic           rx_done_q;
  logic [BW-1:0]  out_cnt_q;

  // FFT beats count only while a window is outstanding
  assign beat_ok_o   = beat_v_i && (state_q == ST_LOAD || state_q == ST_WAIT);
  assign beat_bin_o  = rx_cnt_q;
  assign first_seg_o = (seg_q == '0);
  assign last_seg_o  = (seg_q == SEG_LAST);
  assign col_rd_o    = (state_q == ST_LOAD);
  assign col_addr_o  = base_q + CAW'(ld_cnt_q);
  assign col_last_o  = col_rd_o && (ld_cnt_q == BIN_LAST);
  assign out_rd_o    = (state_q == ST_OUT);
  assign out_addr_o  = out_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      seg_q     <= '0;
      base_q    <= '0;
      ld_cnt_q  <= '0;
      rx_cnt_q  <= '0;
      rx_done_q <= 1'b0;
      out_cnt_q <= '0;
    end else begin
      if (beat_ok_o) begin
        rx_cnt_q <= rx_cnt_q + 1'b1;
        if (rx_cnt_q == BIN_LAST) rx_done_q <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_LOAD;
            seg_q     <= '0;
            base_q    <= '0;
            ld_cnt_q  <= '0;
            rx_cnt_q  <= '0;
            rx_done_q <= 1'b0;
          end
        end
        ST_LOAD: begin
          ld_cnt_q <= ld_cnt_q + 1'b1;
          if (ld_cnt_q == BIN_LAST) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rx_done_q) state_q <= ST_ACC;
        end
        ST_ACC: begin
          // last write of the window lands during this cycle
          rx_done_q <= 1'b0;
          rx_cnt_q  <= '0;
          ld_cnt_q  <= '0;
          if (seg_q == SEG_LAST) begin
            state_q   <= ST_OUT;
            out_cnt_q <= '0;
          end else begin
            seg_q   <= seg_q + 1'b1;
            base_q  <= base_q + CAW'(HOP);
            state_q <= ST_LOAD;
          end
        end
        ST_OUT: begin
          out_cnt_q <= out_cnt_q + 1'b1;
          if (out_cnt_q == BIN_LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/welch_acc.sv
module welch_acc #(
  parameter int BINS = 1024,
  parameter int MW   = 16,
  parameter int SW   = 2,
  localparam int BW   = $clog2(BINS),
  localparam int ACCW = MW + SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_v_i,
  input  logic [BW-1:0] beat_bin_i,
  input  logic [MW-1:0] beat_mag_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic          out_rd_i,
  input  logic [BW-1:0] out_addr_i,
  output logic          avg_valid_o,
  output logic [BW-1:0] avg_bin_o,
  output logic [MW-1:0] avg_data_o,
  output logic          done_o
);
  logic            s1_v, s1_first, s1_last;
  logic [BW-1:0]   s1_bin;
  logic [MW-1:0]   s1_mag;
  logic            ov_q, done_q;
  logic [BW-1:0]   ob_q;
  logic [ACCW-1:0] rd_data, sum, wr_data;
  logic [BW-1:0]   rd_addr;

  assign rd_addr = out_rd_i ? out_addr_i : beat_bin_i;

  welch_ram #(.DEPTH(BINS), .W(ACCW)) u_ram (
    .clk_i    (clk_i),
    .wr_en_i  (s1_v),
    .wr_addr_i(s1_bin),
    .wr_data_i(wr_data),
    .rd_en_i  (out_rd_i | beat_v_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  // first window overwrites; last window scales by 1/N_SEG
  always_comb begin
    sum     = s1_first ? ACCW'(s1_mag) : rd_data + ACCW'(s1_mag);
    wr_data = s1_last ? (sum >> SW) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_bin   <= '0;
      s1_mag   <= '0;
      ov_q     <= 1'b0;
      ob_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      s1_v     <= beat_v_i;
      s1_first <= first_i;
      s1_last  <= last_i;
      s1_bin   <= beat_bin_i;
      s1_mag   <= beat_mag_i;
      ov_q     <= out_rd_i;
      ob_q     <= out_addr_i;
      done_q   <= ov_q && (ob_q == BW'(BINS - 1));
    end
  end

  assign avg_valid_o = ov_q;
  assign avg_bin_o   = ob_q;
  assign avg_data_o  = rd_data[MW-1:0];
  assign done_o      = done_q;
endmodule

// File: rtl/welch_seq.sv
module welch_seq #(
  parameter int SEG_LEN = 1024,
  parameter int N_SEG   = 4,
  parameter int HOP     = 512,
  parameter int DW      = 16,
  parameter int MW      = 16
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          start_i,
  output logic                                          col_rd_o,
  output logic [$clog2((N_SEG-1)*HOP+SEG_LEN)-1:0]      col_addr_o,
  input  logic [DW-1:0]                                 col_data_i,
  output logic                                          fft_in_valid_o,
  output logic [DW-1:0]                                 fft_in_data_o,
  output logic                                          fft_in_last_o,
  input  logic                                          fft_out_valid_i,
  input  logic [MW-1:0]                                 fft_out_mag_i,
  output logic                                          avg_valid_o,
  output logic [$clog2(SEG_LEN)-1:0]                    avg_bin_o,
  output logic [MW-1:0]                                 avg_data_o,
  output logic                                          done_o
);
  localparam int BW = $clog2(SEG_LEN);
  localparam int SW = $clog2(N_SEG);

  logic          col_last, beat_ok, first_seg, last_seg, out_rd;
  logic [BW-1:0] beat_bin, out_addr;
  logic          rd_q, last_q;

  welch_fsm #(.SEG_LEN(SEG_LEN), .N_SEG(N_SEG), .HOP(HOP)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .beat_v_i   (fft_out_valid_i),
    .col_rd_o   (col_rd_o),
    .col_addr_o (col_addr_o),
    .col_last_o (col_last),
    .beat_ok_o  (beat_ok),
    .beat_bin_o (beat_bin),
    .first_seg_o(first_seg),
    .last_seg_o (last_seg),
    .out_rd_o   (out_rd),
    .out_addr_o (out_addr)
  );

  // column buffer has one cycle of read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      rd_q   <= col_rd_o;
      last_q <= col_last;
    end
  end

  assign fft_in_valid_o = rd_q;
  assign fft_in_data_o  = col_data_i;
  assign fft_in_last_o  = last_q;

  welch_acc #(.BINS(SEG_LEN), .MW(MW), .SW(SW)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_v_i   (beat_ok),
    .beat_bin_i (beat_bin),
    .beat_mag_i (fft_out_mag_i),
    .first_i    (first_seg),
    .last_i     (last_seg),
    .out_rd_i   (out_rd),
    .out_addr_i (out_addr),
    .avg_valid_o(avg_valid_o),
    .avg_bin_o  (avg_bin_o),
    .avg_data_o (avg_data_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/welch_seq_chk.sv
module welch_seq_chk #(
  parameter int SEG_LEN = 1024,
  parameter int N_SEG   = 4,
  parameter int HOP     = 512,
  localparam int COL_LEN = (N_SEG - 1) * HOP + SEG_LEN,
  localparam int CAW     = $clog2(COL_LEN),
  localparam int BW      = $clog2(SEG_LEN)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           col_rd_o,
  input logic [CAW-1:0] col_addr_o,
  input logic           fft_in_valid_o,
  input logic           fft_in_last_o,
  input logic           avg_valid_o,
  input logic [BW-1:0]  avg_bin_o,
  input logic           done_o
);
  assert_addr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_rd_o |-> (col_addr_o < CAW'(COL_LEN)));

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_rd_o && $past(col_rd_o)) |-> (col_addr_o == CAW'($past(col_addr_o) + 1'b1)));

  assert_seg_grid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_rd_o && !$past(col_rd_o)) |-> ((col_addr_o % CAW'(HOP)) == '0));

  assert_last_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fft_in_last_o |-> fft_in_valid_o);

  assert_fwd_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fft_in_valid_o |-> $past(col_rd_o));

  assert_bin_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avg_valid_o && avg_bin_o != '0) |-> ($past(avg_valid_o) && avg_bin_o == BW'($past(avg_bin_o) + 1'b1)));

  assert_out_no_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_valid_o |-> !col_rd_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(avg_valid_o) && $past(avg_bin_o) == BW'(SEG_LEN - 1)));
endmodule

bind welch_seq welch_seq_chk #(.SEG_LEN(SEG_LEN), .N_SEG(N_SEG), .HOP(HOP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .col_rd_o      (col_rd_o),
  .col_addr_o    (col_addr_o),
  .fft_in_valid_o(fft_in_valid_o),
  .fft_in_last_o (fft_in_last_o),
  .avg_valid_o   (avg_valid_o),
  .avg_bin_o     (avg_bin_o),
  .done_o        (done_o)
);

// File: tb/sim_welch_seq.sv
`timescale 1ns/1ps
module sim_welch_seq;
  localparam int SEG = 1024;
  localparam int NS  = 4;
  localparam int HOP = 512;
  localparam int COL = (NS - 1) * HOP + SEG;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic        col_rd_o, fft_in_valid_o, fft_in_last_o, avg_valid_o, done_o;
  logic [11:0] col_addr_o;
  logic [15:0] col_data_i, fft_in_data_o, avg_data_o;
  logic        fft_out_valid_i = 1'b0;
  logic [15:0] fft_out_mag_i = '0;
  logic [9:0]  avg_bin_o;

  welch_seq u0 (.*);

  always #5 clk_i = ~clk_i;

  logic [15:0] col_mem [COL];
  always @(posedge clk_i) if (col_rd_o) col_data_i <= col_mem[col_addr_o];

  int nchk = 0, nfail = 0, cyc = 0, gap_mode = 0;
  int rd_cnt = 0, in_cnt = 0, prev_addr = 0;
  bit mon_en = 0, seen_done = 0, exp_done = 0, finished = 0;
  string res_tag = "R5";
  int          exp_addr[$];
  int          exp_bin[$];
  int          exp_val[$];
  logic [15:0] fq[$];

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle monitor, reference model and FFT pass-through model
  always @(negedge clk_i) begin
    int e;
    if (mon_en) begin
      cyc++;
      if (fft_in_valid_o) begin
        chk(fft_in_data_o == col_mem[prev_addr], "R3 data", int'(fft_in_data_o), int'(col_mem[prev_addr]));
        chk(fft_in_last_o == ((in_cnt % SEG) == SEG - 1), "R3 last", int'(fft_in_last_o), int'((in_cnt % SEG) == SEG - 1));
        fq.push_back(fft_in_data_o);
        in_cnt++;
      end else if (fft_in_last_o) chk(0, "R3 last", 1, 0);
      if (col_rd_o) begin
        if ((rd_cnt % SEG) == 0) chk(fq.size() == 0, "R4 window order", fq.size(), 0);
        if (exp_addr.size() == 0) chk(0, "R2 R7 extra read", int'(col_addr_o), -1);
        else begin
          e = exp_addr.pop_front();
          if (int'(col_addr_o) != e) chk(0, "R2 R7 addr", int'(col_addr_o), e);
          else nchk++;
        end
        prev_addr = int'(col_addr_o);
        rd_cnt++;
      end
      if (done_o || exp_done) chk(done_o == exp_done, "R6 done", int'(done_o), int'(exp_done));
      if (done_o) seen_done = 1;
      exp_done = 0;
      if (avg_valid_o) begin
        if (exp_bin.size() == 0) chk(0, "R5 extra beat", int'(avg_bin_o), -1);
        else begin
          e = exp_bin.pop_front();
          chk(int'(avg_bin_o) == e, "R5 bin", int'(avg_bin_o), e);
          e = exp_val.pop_front();
          chk(int'(avg_data_o) == e, res_tag, int'(avg_data_o), e);
        end
        exp_done = (avg_bin_o == 10'(SEG - 1));
      end
      if (fq.size() > 0 && (gap_mode == 0 || (cyc % 3) != 1)) begin
        fft_out_valid_i = 1'b1;
        fft_out_mag_i   = fq.pop_front();
      end else begin
        fft_out_valid_i = 1'b0;
      end
    end
  end

  function automatic logic [15:0] pat(int p, int i);
    case (p)
      0: return 16'(i * 37 + 5);
      1: return 16'hFFFF;
      2: return 16'((i * 40503) ^ ((i >> 3) * 7919));
      default: return 16'(16'hFFFF - i * 13);
    endcase
  endfunction

  task automatic run_col(int p, int gap, bit mid_start, string tag);
    int s;
    for (int i = 0; i < COL; i++) col_mem[i] = pat(p, i);
    for (int w = 0; w < NS; w++)
      for (int k = 0; k < SEG; k++) exp_addr.push_back(w * HOP + k);
    for (int b = 0; b < SEG; b++) begin
      s = 0;
      for (int w = 0; w < NS; w++) s += int'(col_mem[w * HOP + b]);
      exp_bin.push_back(b);
      exp_val.push_back(s >> 2);
    end
    gap_mode  = gap;
    res_tag   = tag;
    seen_done = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    if (mid_start) begin
      // R7: pulses during load and during result wait must be ignored
      repeat (400) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
      repeat (1300) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
    end
    while (!seen_done) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(exp_addr.size() == 0, "R2 reads missing", exp_addr.size(), 0);
    chk(exp_bin.size() == 0, "R5 beats missing", exp_bin.size(), 0);
    chk(!col_rd_o, "R7 idle after done", int'(col_rd_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(!col_rd_o, "R1 col_rd_o", int'(col_rd_o), 0);
    chk(!fft_in_valid_o, "R1 fft_in_valid_o", int'(fft_in_valid_o), 0);
    chk(!fft_in_last_o, "R1 fft_in_last_o", int'(fft_in_last_o), 0);
    chk(!avg_valid_o, "R1 avg_valid_o", int'(avg_valid_o), 0);
    chk(!done_o, "R1 done_o", int'(done_o), 0);
    mon_en = 1;
    repeat (5) @(negedge clk_i);
    run_col(0, 0, 0, "R5 avg");
    run_col(2, 1, 1, "R8 avg");   // R8: distinct data right after, with gaps and stray starts
    run_col(1, 1, 0, "R9 avg");   // R9: full-scale magnitudes
    run_col(3, 0, 1, "R8 avg");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL R5 watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule